// File: doc/BRIEF.md
# Per-Core Interval Tick Timer

This block is a small register-mapped timer that gives one processor core a periodic or single-shot interrupt. A prescaler divides the input clock by a programmable amount. Its ticks drive a down-counter that raises an interrupt pending flag when it runs out. In interval mode the down-counter reloads from its buffer and keeps firing until software clears the start bits. In single-shot mode it parks at zero.

Software programs the prescale buffer and the reload buffer, sets the interrupt enable, and then writes the control word to start the timer. Every write to a configuration register sets a write-acknowledge flag. Software polls that flag and clears it by writing one to it.

Top module: `core_tick_timer`

## Requirements
- R1: After reset every readable register (offsets 0x00, 0x08, 0x20, 0x30, 0x34, 0x40) reads zero and `irq` is low.
- R2: A write to offset 0x00 sets bit 0 of the acknowledge register at 0x40. A write to 0x08 sets bit 1, and a write to 0x20 sets bit 3. Writing ones to 0x40 clears the flags whose bits are set in the written word.
- R3: A write to 0x08 with bit 31 set stores bits 30:0 as the reload count and loads the down-counter with it. A write with bit 31 clear leaves the stored count unchanged, and it still sets the acknowledge flag.
- R4: While control bit 0 is set, the prescaler emits one tick every N+1 clock cycles, where N is the value at offset 0x00.
- R5: While control bit 1 is set, each tick decrements the down-counter. The step from 1 to 0 sets the pending flag (bit 0 at 0x30). When both start bits are set in one write, the pending flag rises C*(N+1) clock edges after that write's edge, where C is the reload count.
- R6: With control bit 2 clear, the counter stays at zero after it expires and produces no further interrupt.
- R7: `irq` is high exactly when the pending flag and bit 0 of the enable register at 0x34 are both set. Writing 1 to bit 0 of 0x30 clears the pending flag.
- R8: With control bit 2 set, the counter reloads on expiry and interrupts repeat every C*(N+1) cycles.
- R9: Clearing the start bits freezes the prescaler and the counter. Setting a start bit again restarts its stage from the buffered values.
- R10: A reload count of zero never sets the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check several internal relationships:
- The pending flag only rises after an expiry.
- A single-shot expiry leaves the counter at zero.
- An interval expiry reloads the buffer.
- A stopped counter holds still.
- Ticks appear only while the prescaler runs.
- A control write is always acknowledged.

Only the bench scenarios can show the end-to-end quantities: the exact C*(N+1) distance from the start write to each interrupt, the period in interval mode, the full reload after a stop and restart, and the absence of any interrupt with a zero count or after a single-shot expiry.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  localparam logic [7:0] OFS_PRESCALE = 8'h00;
  localparam logic [7:0] OFS_RELOAD   = 8'h08;
  localparam logic [7:0] OFS_CTRL     = 8'h20;
  localparam logic [7:0] OFS_PEND     = 8'h30;
  localparam logic [7:0] OFS_IEN      = 8'h34;
  localparam logic [7:0] OFS_WACK     = 8'h40;

  localparam int AK_PRESCALE = 0;
  localparam int AK_RELOAD   = 1;
  localparam int AK_CTRL     = 3;
  localparam int AK_W        = 4;

  typedef struct packed {
    logic interval;
    logic cnt_run;
    logic tick_run;
  } ctrl_t;
endpackage

// File: rtl/ctt_prescaler.sv
module ctt_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] acc;

  function automatic logic at_limit(input logic [W-1:0] a, input logic [W-1:0] l);
    return a >= l;
  endfunction

  assign tick = run && at_limit(acc, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (restart) acc <= '0;
    else if (run)     acc <= tick ? '0 : acc + 1'b1;
  end
endmodule

// File: rtl/ctt_countdown.sv
module ctt_countdown #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload,
  input  logic         step,
  input  logic         interval,
  output logic [W-1:0] cnt,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] after_step(input logic [W-1:0] c,
                                              input logic [W-1:0] r,
                                              input logic         iv);
    if (c == ONE)      return iv ? r : '0;
    else if (c == '0)  return '0;
    else               return c - ONE;
  endfunction

  assign expire = step && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (step)  cnt <= after_step(cnt, reload, interval);
  end
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import ctt_pkg::*;

  localparam int CNT_W = DATA_W - 1;

  logic [DATA_W-1:0] pre_buf;
  logic [CNT_W-1:0]  rld_buf;
  ctrl_t             ctrl;
  logic              pend;
  logic              ien;
  logic [AK_W-1:0]   wack;

  logic wr_pre, wr_rld, wr_ctrl, wr_pend, wr_ien, wr_wack;
  logic rld_take, start_pre, start_cnt, cnt_load;
  logic tick, step, expire;
  logic [CNT_W-1:0] cnt_load_val, cnt;
  logic [AK_W-1:0]  ack_set, ack_clr;
  ctrl_t            ctrl_new;

  assign wr_pre  = bus_wr && (bus_addr == OFS_PRESCALE);
  assign wr_rld  = bus_wr && (bus_addr == OFS_RELOAD);
  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_pend = bus_wr && (bus_addr == OFS_PEND);
  assign wr_ien  = bus_wr && (bus_addr == OFS_IEN);
  assign wr_wack = bus_wr && (bus_addr == OFS_WACK);

  assign ctrl_new  = ctrl_t'(bus_wdata[2:0]);
  assign rld_take  = wr_rld && bus_wdata[DATA_W-1];
  assign start_pre = wr_ctrl && ctrl_new.tick_run && !ctrl.tick_run;
  assign start_cnt = wr_ctrl && ctrl_new.cnt_run && !ctrl.cnt_run;
  assign cnt_load  = rld_take || start_cnt;
  assign cnt_load_val = rld_take ? bus_wdata[CNT_W-1:0] : rld_buf;
  assign step      = tick && ctrl.cnt_run;

  always_comb begin
    ack_set = '0;
    ack_set[AK_PRESCALE] = wr_pre;
    ack_set[AK_RELOAD]   = wr_rld;
    ack_set[AK_CTRL]     = wr_ctrl;
    ack_clr = '0;
    if (wr_wack) begin
      ack_clr[AK_PRESCALE] = bus_wdata[AK_PRESCALE];
      ack_clr[AK_RELOAD]   = bus_wdata[AK_RELOAD];
      ack_clr[AK_CTRL]     = bus_wdata[AK_CTRL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_buf <= '0;
      rld_buf <= '0;
      ctrl    <= '0;
      pend    <= 1'b0;
      ien     <= 1'b0;
      wack    <= '0;
    end else begin
      if (wr_pre)   pre_buf <= bus_wdata;
      if (rld_take) rld_buf <= bus_wdata[CNT_W-1:0];
      if (wr_ctrl)  ctrl    <= ctrl_new;
      if (wr_ien)   ien     <= bus_wdata[0];
      if (expire)                     pend <= 1'b1;
      else if (wr_pend && bus_wdata[0]) pend <= 1'b0;
      wack <= (wack & ~ack_clr) | ack_set;
    end
  end

  ctt_prescaler #(.W(DATA_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl.tick_run), .restart(start_pre),
    .limit(pre_buf), .tick(tick)
  );

  ctt_countdown #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_load_val),
    .reload(rld_buf), .step(step), .interval(ctrl.interval),
    .cnt(cnt), .expire(expire)
  );

  assign irq = pend && ien;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_PRESCALE: bus_rdata = pre_buf;
      OFS_RELOAD:   bus_rdata = {1'b0, rld_buf};
      OFS_CTRL:     bus_rdata = DATA_W'(ctrl);
      OFS_PEND:     bus_rdata = DATA_W'(pend);
      OFS_IEN:      bus_rdata = DATA_W'(ien);
      OFS_WACK:     bus_rdata = DATA_W'(wack);
      default:      bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ctt_checker.sv
module ctt_checker #(
  parameter int CNT_W = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             expire,
  input logic             cnt_load,
  input logic             pend,
  input logic             ien,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] rld_buf,
  input logic [2:0]       ctrl_bits,
  input logic             wr_ctrl,
  input logic [3:0]       wack
);
  assert_tick_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ctrl_bits[0]);

  assert_pend_after_expire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(expire));

  assert_oneshot_parks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_bits[2] && !cnt_load) |=> (cnt == '0));

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien && pend));

  assert_interval_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_bits[2] && !cnt_load) |=> (cnt == $past(rld_buf)));

  assert_frozen_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_bits[1] && !cnt_load) |=> $stable(cnt));

  assert_ctrl_write_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> wack[3]);
endmodule

bind core_tick_timer ctt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .expire(expire), .cnt_load(cnt_load),
  .pend(pend), .ien(ien), .irq(irq), .cnt(cnt), .rld_buf(rld_buf),
  .ctrl_bits(ctrl), .wr_ctrl(wr_ctrl), .wack(wack)
);

// File: tb/core_tick_timer_tb_top.sv
module core_tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int exp_q[$];
  logic irq_q = 1'b0;
  bit done = 1'b0;

  core_tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one register write; optionally queues an interrupt expected exp_d cycles after the write edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input int exp_d, output int w);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    w = cyc + 1;
    if (exp_d >= 0) exp_q.push_back(w + exp_d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare each interrupt rising edge with the queued cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq && !irq_q) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R5/R6/R7 unexpected irq actual=%0d expected=none", cyc);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != cyc) begin
            bad++;
            $display("FAIL R5/R8/R9 irq cycle actual=%0d expected=%0d", cyc, e);
          end
        end
      end
      irq_q <= irq;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, d); check("R1 prescale", d, 0);
    rd(8'h08, d); check("R1 reload", d, 0);
    rd(8'h20, d); check("R1 ctrl", d, 0);
    rd(8'h30, d); check("R1 pend", d, 0);
    rd(8'h34, d); check("R1 ien", d, 0);
    rd(8'h40, d); check("R1 wack", d, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 acknowledge flags
    wr(8'h00, 32'd1, -1, w);
    rd(8'h40, d); check("R2 ack prescale", d, 32'h1);
    wr(8'h40, 32'h1, -1, w);
    rd(8'h40, d); check("R2 ack cleared", d, 32'h0);

    // R3 reload update only with bit 31
    wr(8'h08, 32'h8000_0004, -1, w);
    rd(8'h08, d); check("R3 reload taken", d, 32'h4);
    rd(8'h40, d); check("R2 ack reload", d, 32'h2);
    wr(8'h08, 32'h0000_0055, -1, w);
    rd(8'h08, d); check("R3 reload ignored", d, 32'h4);
    wr(8'h40, 32'hB, -1, w);

    // R4 R5 single-shot: N=1, C=4 -> irq 8 cycles after start
    wr(8'h34, 32'h1, -1, w);
    wr(8'h20, 32'h3, 8, w);
    rd(8'h40, d); check("R2 ack ctrl", d, 32'h8);
    idle(12);
    rd(8'h30, d); check("R5 pend set", d, 1);
    wr(8'h30, 32'h1, -1, w);
    rd(8'h30, d); check("R7 pend cleared", d, 0);
    // R6 no further interrupt
    idle(40);
    rd(8'h30, d); check("R6 no repeat", d, 0);
    wr(8'h20, 32'h0, -1, w);

    // R7 masking: ien=0, N=0, C=3
    wr(8'h34, 32'h0, -1, w);
    wr(8'h00, 32'd0, -1, w);
    wr(8'h08, 32'h8000_0003, -1, w);
    wr(8'h20, 32'h3, -1, w);
    idle(10);
    rd(8'h30, d); check("R7 pend while masked", d, 1);
    check("R7 irq masked", {31'b0, irq}, 0);
    wr(8'h34, 32'h1, 0, w);
    check("R7 irq unmasked", {31'b0, irq}, 1);
    wr(8'h20, 32'h0, -1, w);
    wr(8'h30, 32'h1, -1, w);

    // R8 interval: N=2, C=3 -> period 9
    wr(8'h00, 32'd2, -1, w);
    wr(8'h20, 32'h7, 9, w);
    exp_q.push_back(w + 18);
    exp_q.push_back(w + 27);
    for (int k = 0; k < 3; k++) begin
      wait (irq === 1'b1);
      if (k == 2) wr(8'h20, 32'h0, -1, w);
      wr(8'h30, 32'h1, -1, w);
    end
    idle(30);
    check("R8 all interval irqs seen", exp_q.size(), 0);

    // R9 freeze and restart: N=0, C=10
    wr(8'h00, 32'd0, -1, w);
    wr(8'h08, 32'h8000_000A, -1, w);
    wr(8'h20, 32'h3, -1, w);
    idle(4);
    wr(8'h20, 32'h0, -1, w);
    idle(20);
    rd(8'h30, d); check("R9 frozen no pend", d, 0);
    wr(8'h20, 32'h3, 10, w);
    idle(14);
    check("R9 restart irq seen", exp_q.size(), 0);
    wr(8'h20, 32'h0, -1, w);
    wr(8'h30, 32'h1, -1, w);

    // R10 zero count never fires
    wr(8'h08, 32'h8000_0000, -1, w);
    wr(8'h20, 32'h7, -1, w);
    idle(40);
    rd(8'h30, d); check("R10 zero count", d, 0);
    wr(8'h20, 32'h0, -1, w);

    idle(5);
    check("R5 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule